// File: doc/BRIEF.md
# Count-Prefixed CRC Frame Checker

This block checks the framing of one command or response block delivered as a byte stream. The first byte of a block is a count of every byte in the block: the count itself, the packet bytes and the two CRC bytes. The packet bytes follow, and the two CRC bytes close the block. A 16-bit CRC is run over the count and packet bytes and compared with the trailing pair. The block then reports the result with a one-cycle done pulse, a match flag and a length-error flag.

Bytes arrive on a valid/ready interface. A start strobe marks the count byte. Packet bytes are forwarded on a valid/ready output stream that marks the final packet byte. The forwarding path is combinational and has no storage:

- While a packet byte is on offer, `in_ready` equals `out_ready`, so back-pressure from downstream stalls the source directly.
- The count byte and the CRC bytes are never forwarded, and the block always accepts them.
- A source must hold `in_data` and `in_sob` stable while `in_valid` is high and `in_ready` is low.

Top module: `fchk_top`

## Requirements
- R1: While no block is in progress, an accepted byte with `in_sob` low is discarded. It produces no output byte and no done pulse. An accepted byte with `in_sob` high is taken as the count byte of a new block.
- R2: For a count C in 4..39, the next C-3 accepted bytes are packet bytes and are forwarded unchanged on the output stream. `out_last` is high only on the final one.
- R3: While a packet byte is offered, `in_ready` follows `out_ready`, and `out_valid` is high with `out_data` equal to `in_data`. At all other times `in_ready` is 1 and `out_valid` is 0.
- R4: The CRC register starts at zero and covers the count byte and the packet bytes. Each byte is fed least significant bit first. For each bit, the feedback is the incoming bit XOR the register MSB, the register shifts left, and the register is XORed with 0x8005 when the feedback is 1.
- R5: The two bytes after the packet are the expected CRC, low byte first and high byte last. `crc_ok` is 1 only when they equal the computed register.
- R6: `done` is high for exactly one cycle, the cycle after the final byte of the block is accepted. `crc_ok` is never high without `done`.
- R7: A count outside 4..39 forwards nothing. The block then spans 39 accepted bytes in total, including the count byte. After the 39th byte, `done` and `len_err` pulse together and `crc_ok` stays 0.
- R8: `in_sob` has no effect on any byte accepted while a block is in progress.
- R9: During reset, `in_ready` is 1 and `out_valid`, `done`, `crc_ok` and `len_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Input byte taken at this edge when valid |
| in_sob | input | 1 | Offered byte is the count byte of a new block |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Packet byte offered downstream |
| out_ready | input | 1 | Downstream takes the packet byte |
| out_data | output | 8 | Packet byte |
| out_last | output | 1 | Offered packet byte is the last of the block |
| done | output | 1 | One-cycle pulse: block finished |
| crc_ok | output | 1 | With done: received CRC matched |
| len_err | output | 1 | With done: count byte was out of range |

## Verification
Every legal count from 4 to 39 is sent with random packet contents and a correct CRC. This shows that the length decode, the forwarding and the CRC agree across the whole range. Each count is sent again with one bit flipped at a random position. For one small count, a flipped bit is placed at every position, including both CRC bytes. These corrupted frames tell a correct comparison apart from a checker that ignores a byte or swaps the order of the CRC bytes.

Out-of-range counts check that the block spans exactly 39 bytes, no more and no fewer. Extra start strobes inside blocks check that the strobe is ignored mid-block. Stray bytes in idle check that they are discarded. Random downstream stalls check that back-pressure reaches the source.

// File: rtl/fchk_pkg.sv
package fchk_pkg;

  // Phases of one block
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PKT,
    ST_CRC_LO,
    ST_CRC_HI,
    ST_DRAIN
  } fchk_state_e;

  // Number of trailing check bytes after the packet
  localparam int unsigned TAIL_BYTES = 2;

endpackage

// File: rtl/fchk_crc.sv
// Bit-serial CRC register, unrolled to process one byte per cycle.
module fchk_crc #(
  parameter int unsigned    CW   = 16,
  parameter logic [CW-1:0]  POLY = 16'h8005,
  parameter int unsigned    DW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,   // restart from zero with din
  input  logic          step,    // continue with din
  input  logic [DW-1:0] din,
  output logic [CW-1:0] crc
);

  logic [CW-1:0] crc_q;
  logic [CW-1:0] chain [0:DW];

  assign chain[0] = start ? '0 : crc_q;

  // LSB of the byte enters first
  for (genvar k = 0; k < DW; k++) begin : g_bit
    logic fb;
    assign fb = chain[k][CW-1] ^ din[k];
    assign chain[k+1] = {chain[k][CW-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            crc_q <= '0;
    else if (start | step) crc_q <= chain[DW];
  end

  assign crc = crc_q;

endmodule

// File: rtl/fchk_seq.sv
// Block sequencer: length decode, phase tracking, CRC compare, result pulses.
module fchk_seq
  import fchk_pkg::*;
#(
  parameter int unsigned CNT_MIN = 4,
  parameter int unsigned CNT_MAX = 39,
  parameter int unsigned DW      = 8,
  parameter int unsigned CW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sob,
  input  logic [DW-1:0] in_data,
  input  logic          out_ready,
  input  logic [CW-1:0] crc_val,
  output logic          in_ready,
  output logic          fwd,
  output logic          fwd_last,
  output logic          crc_start,
  output logic          crc_step,
  output logic          done,
  output logic          crc_ok,
  output logic          len_err
);

  localparam int unsigned RW = $clog2(CNT_MAX + 1);
  localparam logic [DW-1:0] MIN_B   = DW'(CNT_MIN);
  localparam logic [DW-1:0] MAX_B   = DW'(CNT_MAX);
  localparam logic [RW-1:0] HDR_SUB = RW'(TAIL_BYTES + 1);
  localparam logic [RW-1:0] DRAIN_N = RW'(CNT_MAX - 1);
  localparam logic [RW-1:0] ONE     = RW'(1);

  fchk_state_e   st_q;
  logic [RW-1:0] rem_q;
  logic [DW-1:0] lo_q;
  logic          done_q, ok_q, lerr_q;
  logic          acc, legal;

  assign in_ready  = (st_q == ST_PKT) ? out_ready : 1'b1;
  assign acc       = in_valid & in_ready;
  assign legal     = (in_data >= MIN_B) && (in_data <= MAX_B);
  assign fwd       = (st_q == ST_PKT);
  assign fwd_last  = (st_q == ST_PKT) && (rem_q == ONE);
  assign crc_start = acc && (st_q == ST_IDLE) && in_sob;
  assign crc_step  = acc && (st_q == ST_PKT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rem_q  <= '0;
      lo_q   <= '0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      lerr_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      lerr_q <= 1'b0;
      if (acc) begin
        unique case (st_q)
          ST_IDLE: begin
            if (in_sob) begin
              if (legal) begin
                rem_q <= RW'(in_data) - HDR_SUB;
                st_q  <= ST_PKT;
              end else begin
                rem_q <= DRAIN_N;
                st_q  <= ST_DRAIN;
              end
            end
          end
          ST_PKT: begin
            rem_q <= rem_q - ONE;
            if (rem_q == ONE) st_q <= ST_CRC_LO;
          end
          ST_CRC_LO: begin
            lo_q <= in_data;
            st_q <= ST_CRC_HI;
          end
          ST_CRC_HI: begin
            done_q <= 1'b1;
            ok_q   <= (crc_val == {in_data, lo_q});
            st_q   <= ST_IDLE;
          end
          ST_DRAIN: begin
            rem_q <= rem_q - ONE;
            if (rem_q == ONE) begin
              done_q <= 1'b1;
              lerr_q <= 1'b1;
              st_q   <= ST_IDLE;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign done    = done_q;
  assign crc_ok  = ok_q;
  assign len_err = lerr_q;

  // R6: a match is only reported with the completion pulse
  p_ok_needs_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    crc_ok |-> done);

  // R6: completion lasts one cycle
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: a length error completes the block without a match
  p_lenerr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> (done && !crc_ok));

  // R3: a stalled input leaves the sequencer untouched
  p_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(st_q) && $stable(rem_q)));

  // R2: the packet phase never runs with an empty byte budget
  p_rem_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PKT) |-> (rem_q != '0));

  // R8: a start strobe inside the packet does not leave the packet phase early
  p_sob_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_sob && st_q == ST_PKT && rem_q > ONE) |=> (st_q == ST_PKT));

endmodule

// File: rtl/fchk_top.sv
module fchk_top
  import fchk_pkg::*;
#(
  parameter int unsigned CNT_MIN = 4,
  parameter int unsigned CNT_MAX = 39,
  parameter int unsigned DW      = 8,
  parameter int unsigned CW      = 16,
  parameter logic [15:0] POLY    = 16'h8005
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_sob,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  output logic          done,
  output logic          crc_ok,
  output logic          len_err
);

  logic          fwd, fwd_last, crc_start, crc_step;
  logic [CW-1:0] crc_val;

  fchk_seq #(
    .CNT_MIN (CNT_MIN),
    .CNT_MAX (CNT_MAX),
    .DW      (DW),
    .CW      (CW)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sob    (in_sob),
    .in_data   (in_data),
    .out_ready (out_ready),
    .crc_val   (crc_val),
    .in_ready  (in_ready),
    .fwd       (fwd),
    .fwd_last  (fwd_last),
    .crc_start (crc_start),
    .crc_step  (crc_step),
    .done      (done),
    .crc_ok    (crc_ok),
    .len_err   (len_err)
  );

  fchk_crc #(
    .CW   (CW),
    .POLY (CW'(POLY)),
    .DW   (DW)
  ) crc_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (crc_start),
    .step  (crc_step),
    .din   (in_data),
    .crc   (crc_val)
  );

  // Combinational pass-through of packet bytes
  assign out_valid = fwd & in_valid;
  assign out_data  = in_data;
  assign out_last  = fwd & fwd_last;

  // R3: a byte taken downstream is also taken from the source
  p_passthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> in_ready);

  // R2: the last marker only appears on a forwarded byte
  p_last_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_last && in_valid) |-> out_valid);

endmodule

// File: tb/fchk_top_tb_top.sv
module fchk_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MAXB = 39;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready, in_sob;
  logic [7:0] in_data;
  logic       out_valid, out_ready, out_last;
  logic [7:0] out_data;
  logic       done, crc_ok, len_err;

  int checks = 0;
  int errors = 0;

  logic [7:0] fr  [0:MAXB-1];
  logic [7:0] got [0:63];
  int got_n, last_cnt, last_idx, done_cnt;
  logic ok_v, le_v;

  always #(CLK_PERIOD/2) clk = ~clk;

  fchk_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_sob(in_sob), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .done(done), .crc_ok(crc_ok), .len_err(len_err)
  );

  task automatic chk(input bit cond, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Observer, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) begin
        if (got_n < 64) got[got_n] = out_data;
        if (out_last) begin last_cnt++; last_idx = got_n; end
        got_n++;
      end
      if (done) begin
        done_cnt++;
        ok_v = crc_ok;
        le_v = len_err;
      end
    end
  end

  function automatic logic [15:0] ref_crc(input int len);
    logic [15:0] r;
    r = 16'h0000;
    for (int i = 0; i < len; i++) begin
      for (int k = 0; k < 8; k++) begin
        logic t;
        t = r[15] ^ fr[i][k];
        r = {r[14:0], 1'b0};
        if (t) r = r ^ 16'h8005;
      end
    end
    return r;
  endfunction

  task automatic clear_obs();
    got_n = 0; last_cnt = 0; last_idx = -1; done_cnt = 0; ok_v = 0; le_v = 0;
  endtask

  // kind 1 = packet byte, otherwise a byte the block keeps for itself
  task automatic send_byte(input logic [7:0] d, input logic s, input int kind);
    bit taken;
    in_valid = 1'b1; in_data = d; in_sob = s;
    taken = 0;
    while (!taken) begin
      out_ready = ($urandom % 4) != 0;
      @(negedge clk);
      if (kind == 1) begin
        if (!out_ready)
          chk(in_ready == 1'b0, "R3", "stall reaches source", int'(in_ready), 0);
        chk(out_valid == 1'b1 && out_data == d, "R3", "packet byte offered",
            int'(out_data), int'(d));
      end else begin
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R3", "non-packet byte not forwarded",
            int'({in_ready, out_valid}), 2);
      end
      taken = in_ready;
      @(posedge clk); #1;
    end
    in_valid = 1'b0; in_sob = 1'b0;
    if (($urandom % 3) == 0) begin @(posedge clk); #1; end
  endtask

  task automatic wait_settle();
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic run_legal(input int cnt, input int cpos, input bit mid_sob);
    logic [15:0] c;
    int n;
    n = cnt;
    fr[0] = 8'(cnt);
    for (int i = 1; i <= n - 3; i++) fr[i] = 8'($urandom);
    c = ref_crc(n - 2);                      // R4 model
    fr[n-2] = c[7:0];                        // R5: low byte first
    fr[n-1] = c[15:8];
    if (cpos > 0) fr[cpos] = fr[cpos] ^ (8'h01 << ($urandom % 8));
    clear_obs();
    for (int i = 0; i < n; i++) begin
      logic s;
      s = (i == 0) || (mid_sob && (i == 1 || i == n - 2));   // R8
      send_byte(fr[i], s, (i >= 1 && i <= n - 3) ? 1 : 0);
    end
    wait_settle();
    chk(done_cnt == 1, "R6", "one done pulse", done_cnt, 1);
    chk(ok_v == (cpos <= 0), "R5", "crc match flag", int'(ok_v), int'(cpos <= 0));
    chk(le_v == 1'b0, "R7", "no length error on legal count", int'(le_v), 0);
    chk(got_n == n - 3, "R2", "forwarded byte count", got_n, n - 3);
    for (int i = 0; i < n - 3 && i < got_n; i++)
      chk(got[i] == fr[i+1], "R2", "forwarded byte value", int'(got[i]), int'(fr[i+1]));
    chk(last_cnt == 1 && last_idx == n - 4, "R2", "last marker position", last_idx, n - 4);
    if (mid_sob)
      chk(ok_v == 1'b1 && got_n == n - 3, "R8", "start strobe mid-block ignored",
          int'(ok_v), 1);
  endtask

  task automatic run_bad(input int cnt);
    clear_obs();
    fr[0] = 8'(cnt);
    for (int i = 1; i < MAXB; i++) fr[i] = 8'($urandom);
    for (int i = 0; i < MAXB - 1; i++) send_byte(fr[i], (i % 5) == 0, 0);
    repeat (2) @(posedge clk); #1;
    chk(done_cnt == 0, "R7", "no completion before 39th byte", done_cnt, 0);
    send_byte(fr[MAXB-1], 1'b0, 0);
    wait_settle();
    chk(done_cnt == 1, "R7", "completion after 39 bytes", done_cnt, 1);
    chk(le_v == 1'b1, "R7", "length error flagged", int'(le_v), 1);
    chk(ok_v == 1'b0, "R7", "no match on bad count", int'(ok_v), 0);
    chk(got_n == 0, "R7", "nothing forwarded", got_n, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sob = 1'b0; in_data = '0; out_ready = 1'b1;
    clear_obs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready == 1'b1, "R9", "reset in_ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R9", "reset out_valid", int'(out_valid), 0);
    chk(done == 1'b0 && crc_ok == 1'b0 && len_err == 1'b0, "R9", "reset pulses",
        int'({done, crc_ok, len_err}), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // R1: stray bytes while idle
    clear_obs();
    for (int i = 0; i < 6; i++) send_byte(8'd4 + 8'(i), 1'b0, 0);
    wait_settle();
    chk(got_n == 0 && done_cnt == 0, "R1", "idle bytes discarded", got_n + done_cnt, 0);
    run_legal(4, -1, 1'b0);
    chk(ok_v == 1'b1, "R1", "block starts after stray bytes", int'(ok_v), 1);

    // Legal count sweep, clean and corrupted
    for (int c = 4; c <= 39; c++) begin
      run_legal(c, -1, (c % 3) == 0);
      run_legal(c, 1 + int'($urandom % (c - 1)), 1'b0);
    end

    // Corruption at every position of a short block, both CRC bytes included
    for (int p = 1; p < 8; p++) run_legal(8, p, 1'b0);

    // Out-of-range counts
    run_bad(0);   run_bad(1);   run_bad(2);   run_bad(3);
    run_bad(40);  run_bad(41);  run_bad(63);  run_bad(128); run_bad(255);

    // Recovery after a bad block
    run_legal(39, -1, 1'b1);
    finish_up();
  end

endmodule